// File: doc/BRIEF.md
# Scanline Interrupt Down-Counter with Scrambled Reload

This block counts visible scanlines and raises a level interrupt a programmable number of lines after it has been armed. Software writes a reload value into a latch, arms the counter, and waits for the interrupt. The line source gives a one-cycle strobe per scanline, together with the current line number and a flag that says whether rendering is on. A line is counted only when the strobe is high, the line number is in the visible range, and rendering is on.

The value written to the latch can be transformed by an offset register. When the top bit of the offset is set, the data is XORed with the offset with its lowest bit forced to one. When the top bit is clear, the data is ORed with the offset after a fixed mask is applied to it. The offset register can only be written when a configuration input permits it. A latch write or an arm write does not load the counter at once. It raises a request flag, and the counter takes the latch on the next counted line.

Top module: `scanline_irq_timer`

## Requirements
- R1: After reset, the enable, counter, latch, offset and reload request are all zero and `irq` is low. An arm write with no latch write therefore raises `irq` on the first counted line.
- R2: A write is decoded on `wr_addr & 16'hF007`. The codes are 0xC002 (disarm), 0xC003 (arm), 0xC005 (latch) and 0xC006 (offset). Any other masked value has no effect, and aliases such as 0xC00A act as their masked code.
- R3: A disarm write clears the enable and drops `irq` at the next clock. Counted lines after a disarm do not raise `irq`.
- R4: An arm write sets the enable and sets the reload request. It does not clear an `irq` that is already high.
- R5: A latch write stores `wr_data ^ (offset | 8'h01)` when offset bit 7 is 1. Otherwise it stores `wr_data | (offset & 8'h27)`. The write also sets the reload request.
- R6: An offset write takes effect only while `scramble_en` is high. Otherwise the offset keeps its value, which is zero after reset.
- R7: A line is counted only when `line_strobe` is high, `line_num` <= 239 and `render_on` is high. On any other cycle the counter and a low `irq` are unchanged.
- R8: On a counted line the steps run in this order: a pending reload loads the latch and clears the request, a nonzero counter decrements, and `irq` sets if the counter is then zero and the block is enabled. A latch value N > 0 raises `irq` on the Nth counted line after arming. A latch value of 0 raises it on the first counted line.
- R9: Once high, `irq` stays high until a disarm write.
- R10: When a register write and a counted line fall in the same cycle, the write is applied first and the line step sees the updated enable, latch and request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scramble_en | input | 1 | Permits writes to the offset register |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Write address, decoded after masking |
| wr_data | input | 8 | Write data |
| line_strobe | input | 1 | One-cycle pulse per scanline |
| line_num | input | 9 | Current scanline number |
| render_on | input | 1 | Rendering enabled |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is a register write landing in the same cycle as a counted line. The ordering rule only shows up there, and the normal flow keeps the two apart. The bench drives a write and a strobe in one cycle, choosing states where the order changes the result: an arm write with a zero latch must raise `irq` in that very cycle, and a disarm write with the counter at zero must leave `irq` low. Scramble results that need many lines to expire, such as 254, are reached by streaming counted strobes from a loop over a vector table.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

   typedef enum logic [2:0] {
      SIRQ_CMD_NONE,
      SIRQ_CMD_DISARM,
      SIRQ_CMD_ARM,
      SIRQ_CMD_LATCH,
      SIRQ_CMD_OFFSET
   } sirq_cmd_e;

endpackage

// File: rtl/sirq_decode.sv
module sirq_decode
   import sirq_pkg::*;
#(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned ADDR_MASK   = 'hF007,
   parameter int unsigned ADDR_DISARM = 'hC002,
   parameter int unsigned ADDR_ARM    = 'hC003,
   parameter int unsigned ADDR_LATCH  = 'hC005,
   parameter int unsigned ADDR_OFFSET = 'hC006
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   output sirq_cmd_e         cmd
);

   localparam logic [ADDR_W-1:0] MASK_V   = ADDR_W'(ADDR_MASK);
   localparam logic [ADDR_W-1:0] DISARM_V = ADDR_W'(ADDR_DISARM);
   localparam logic [ADDR_W-1:0] ARM_V    = ADDR_W'(ADDR_ARM);
   localparam logic [ADDR_W-1:0] LATCH_V  = ADDR_W'(ADDR_LATCH);
   localparam logic [ADDR_W-1:0] OFFSET_V = ADDR_W'(ADDR_OFFSET);

   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("sirq_decode: ADDR_W too small");
      end
      if (DISARM_V == ARM_V || DISARM_V == LATCH_V || DISARM_V == OFFSET_V ||
          ARM_V == LATCH_V || ARM_V == OFFSET_V || LATCH_V == OFFSET_V) begin : g_bad_map
         $error("sirq_decode: register codes must be distinct");
      end
   endgenerate

   logic [ADDR_W-1:0] masked;

   always_comb begin
      masked = wr_addr & MASK_V;
      cmd    = SIRQ_CMD_NONE;
      if (wr_en) begin
         if (masked == DISARM_V)      cmd = SIRQ_CMD_DISARM;
         else if (masked == ARM_V)    cmd = SIRQ_CMD_ARM;
         else if (masked == LATCH_V)  cmd = SIRQ_CMD_LATCH;
         else if (masked == OFFSET_V) cmd = SIRQ_CMD_OFFSET;
      end
   end

endmodule

// File: rtl/sirq_regs.sv
module sirq_regs
   import sirq_pkg::*;
#(
   parameter int unsigned DATA_W       = 8,
   parameter bit          HAS_SCRAMBLE = 1'b1,
   parameter int unsigned XOR_SEL_BIT  = 7,
   parameter int unsigned OR_MASK      = 'h27
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sirq_cmd_e         cmd,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              scramble_en,
   input  logic              step,
   output logic              en_nx,
   output logic              req_nx,
   output logic [DATA_W-1:0] latch_nx,
   output logic              disarm
);

   localparam logic [DATA_W-1:0] ONE_V  = DATA_W'(1);
   localparam logic [DATA_W-1:0] MASK_V = DATA_W'(OR_MASK);

   generate
      if (XOR_SEL_BIT >= DATA_W) begin : g_bad_bit
         $error("sirq_regs: XOR_SEL_BIT outside data width");
      end
   endgenerate

   logic              en_q;
   logic              req_q;
   logic [DATA_W-1:0] latch_q;
   logic [DATA_W-1:0] off_q;
   logic [DATA_W-1:0] scrambled;

   // offset register exists only in the scrambling variant
   generate
      if (HAS_SCRAMBLE) begin : g_offset
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               off_q <= '0;
            end else if (cmd == SIRQ_CMD_OFFSET && scramble_en) begin
               off_q <= wr_data;
            end
         end
      end else begin : g_no_offset
         assign off_q = '0;
      end
   endgenerate

   always_comb begin
      if (off_q[XOR_SEL_BIT]) scrambled = wr_data ^ (off_q | ONE_V);
      else                    scrambled = wr_data | (off_q & MASK_V);
   end

   // state after this cycle's write; the line step consumes these
   always_comb begin
      en_nx    = en_q;
      req_nx   = req_q;
      latch_nx = latch_q;
      unique case (cmd)
         SIRQ_CMD_DISARM: en_nx = 1'b0;
         SIRQ_CMD_ARM: begin
            en_nx  = 1'b1;
            req_nx = 1'b1;
         end
         SIRQ_CMD_LATCH: begin
            latch_nx = scrambled;
            req_nx   = 1'b1;
         end
         default: ;
      endcase
   end

   assign disarm = (cmd == SIRQ_CMD_DISARM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         req_q   <= 1'b0;
         latch_q <= '0;
      end else begin
         en_q    <= en_nx;
         latch_q <= latch_nx;
         req_q   <= step ? 1'b0 : req_nx;
      end
   end

endmodule

// File: rtl/sirq_counter.sv
module sirq_counter #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned LINE_W    = 9,
   parameter int unsigned LAST_LINE = 239
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_strobe,
   input  logic [LINE_W-1:0] line_num,
   input  logic              render_on,
   input  logic              en_nx,
   input  logic              req_nx,
   input  logic [DATA_W-1:0] latch_nx,
   input  logic              disarm,
   output logic              step,
   output logic [DATA_W-1:0] count_q,
   output logic              irq
);

   localparam logic [LINE_W-1:0] LAST_V = LINE_W'(LAST_LINE);

   generate
      if (LAST_LINE >= (1 << LINE_W)) begin : g_bad_line
         $error("sirq_counter: LAST_LINE does not fit LINE_W");
      end
   endgenerate

   logic [DATA_W-1:0] loaded;
   logic [DATA_W-1:0] stepped;
   logic              hit;

   always_comb begin
      step    = line_strobe && render_on && (line_num <= LAST_V);
      loaded  = req_nx ? latch_nx : count_q;
      stepped = (loaded != '0) ? loaded - DATA_W'(1) : loaded;
      hit     = step && (stepped == '0) && en_nx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
         irq     <= 1'b0;
      end else begin
         if (step) count_q <= stepped;
         if (disarm)   irq <= 1'b0;
         else if (hit) irq <= 1'b1;
      end
   end

endmodule

// File: rtl/scanline_irq_timer.sv
module scanline_irq_timer
   import sirq_pkg::*;
#(
   parameter int unsigned ADDR_W       = 16,
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned LINE_W       = 9,
   parameter int unsigned LAST_LINE    = 239,
   parameter bit          HAS_SCRAMBLE = 1'b1,
   parameter int unsigned ADDR_MASK    = 'hF007
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scramble_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              line_strobe,
   input  logic [LINE_W-1:0] line_num,
   input  logic              render_on,
   output logic              irq
);

   sirq_cmd_e         cmd;
   logic              en_nx;
   logic              req_nx;
   logic [DATA_W-1:0] latch_nx;
   logic              disarm;
   logic              step;
   logic [DATA_W-1:0] count_q;

   sirq_decode #(
      .ADDR_W   (ADDR_W),
      .ADDR_MASK(ADDR_MASK)
   ) u_decode (
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .cmd    (cmd)
   );

   sirq_regs #(
      .DATA_W      (DATA_W),
      .HAS_SCRAMBLE(HAS_SCRAMBLE)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd        (cmd),
      .wr_data    (wr_data),
      .scramble_en(scramble_en),
      .step       (step),
      .en_nx      (en_nx),
      .req_nx     (req_nx),
      .latch_nx   (latch_nx),
      .disarm     (disarm)
   );

   sirq_counter #(
      .DATA_W   (DATA_W),
      .LINE_W   (LINE_W),
      .LAST_LINE(LAST_LINE)
   ) u_counter (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_strobe(line_strobe),
      .line_num   (line_num),
      .render_on  (render_on),
      .en_nx      (en_nx),
      .req_nx     (req_nx),
      .latch_nx   (latch_nx),
      .disarm     (disarm),
      .step       (step),
      .count_q    (count_q),
      .irq        (irq)
   );

endmodule

// File: rtl/sirq_checker.sv
module sirq_checker #(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned LINE_W      = 9,
   parameter int unsigned LAST_LINE   = 239,
   parameter int unsigned ADDR_MASK   = 'hF007,
   parameter int unsigned ADDR_DISARM = 'hC002
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              line_strobe,
   input logic [LINE_W-1:0] line_num,
   input logic              render_on,
   input logic [DATA_W-1:0] count_q,
   input logic              irq
);

   logic counted;
   logic disarm_wr;

   assign counted   = line_strobe && render_on && (line_num <= LINE_W'(LAST_LINE));
   assign disarm_wr = wr_en && ((wr_addr & ADDR_W'(ADDR_MASK)) == ADDR_W'(ADDR_DISARM));

   assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |=> !irq);

   assert_disarm_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
      disarm_wr |=> !irq);

   assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !disarm_wr |=> irq);

   assert_idle_no_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !irq && !counted |=> !irq);

   assert_idle_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !counted |=> $stable(count_q));

   assert_raise_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> (count_q == '0));

endmodule

bind scanline_irq_timer sirq_checker #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .LINE_W   (LINE_W),
   .LAST_LINE(LAST_LINE),
   .ADDR_MASK(ADDR_MASK)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .line_strobe(line_strobe),
   .line_num   (line_num),
   .render_on  (render_on),
   .count_q    (count_q),
   .irq        (irq)
);

// File: tb/scanline_irq_timer_tb.sv
`timescale 1ns/1ps
module scanline_irq_timer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scramble_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        line_strobe = 1'b0;
   logic [8:0]  line_num = '0;
   logic        render_on = 1'b1;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   scanline_irq_timer u_dut (
      .clk(clk), .rst_n(rst_n), .scramble_en(scramble_en),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .line_strobe(line_strobe), .line_num(line_num),
      .render_on(render_on), .irq(irq)
   );

   // {data, offset, allow, expected lines until irq}
   localparam logic [31:0] VEC [8] = '{
      {8'h05, 8'h00, 8'h00, 8'd5},
      {8'h03, 8'h84, 8'h01, 8'd134},
      {8'h08, 8'h24, 8'h01, 8'd44},
      {8'h08, 8'h84, 8'h00, 8'd8},
      {8'h00, 8'h00, 8'h01, 8'd1},
      {8'h10, 8'h5F, 8'h01, 8'd23},
      {8'h01, 8'hFF, 8'h01, 8'd254},
      {8'h86, 8'h80, 8'h01, 8'd7}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic write_reg(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse_line(input int n, input bit rend);
      @(negedge clk);
      line_strobe = 1'b1; line_num = 9'(n); render_on = rend;
      @(negedge clk);
      line_strobe = 1'b0; render_on = 1'b1;
   endtask

   task automatic line_and_write(input int n, input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      line_strobe = 1'b1; line_num = 9'(n);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      line_strobe = 1'b0; wr_en = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      do_reset();
      check(irq == 1'b0, "R1 irq low after reset", irq, 0);
      write_reg(16'hC003, 8'h00);
      pulse_line(10, 1'b1);
      check(irq == 1'b1, "R1 zero latch fires on first line", irq, 1);

      // vector table: R5, R6, R8
      for (int v = 0; v < 8; v++) begin
         int n;
         do_reset();
         scramble_en = VEC[v][8];
         write_reg(16'hC006, VEC[v][23:16]);
         write_reg(16'hC005, VEC[v][31:24]);
         write_reg(16'hC003, 8'h00);
         scramble_en = 1'b0;
         n = 0;
         for (int k = 0; k < 300; k++) begin
            pulse_line(k % 240, 1'b1);
            n++;
            if (irq) break;
         end
         check(n == int'(VEC[v][7:0]), "R5 R6 R8 lines until irq", n, int'(VEC[v][7:0]));
      end

      // R7: non-counted lines
      do_reset();
      write_reg(16'hC005, 8'h02);
      write_reg(16'hC003, 8'h00);
      pulse_line(240, 1'b1);
      pulse_line(300, 1'b1);
      pulse_line(5, 1'b0);
      pulse_line(239, 1'b1);
      check(irq == 1'b0, "R7 only one line counted", irq, 0);
      pulse_line(0, 1'b1);
      check(irq == 1'b1, "R7 second counted line fires", irq, 1);

      // R9 and R4: sticky irq
      pulse_line(250, 1'b1);
      check(irq == 1'b1, "R9 irq holds", irq, 1);
      write_reg(16'hC003, 8'h00);
      check(irq == 1'b1, "R4 arm does not clear irq", irq, 1);

      // R2: unused codes ignored, alias decodes
      write_reg(16'hC001, 8'hFF);
      write_reg(16'hB005, 8'hFF);
      write_reg(16'hC004, 8'hFF);
      check(irq == 1'b1, "R2 unused codes ignored", irq, 1);
      write_reg(16'hC00A, 8'h00);
      check(irq == 1'b0, "R2 alias of disarm", irq, 0);

      // R3: disarm keeps irq low on counted lines
      write_reg(16'hC003, 8'h00);
      write_reg(16'hC002, 8'h00);
      pulse_line(1, 1'b1);
      pulse_line(2, 1'b1);
      check(irq == 1'b0, "R3 disarmed stays quiet", irq, 0);

      // R10: arm in the same cycle as a counted line, zero latch
      do_reset();
      line_and_write(3, 16'hC003, 8'h00);
      check(irq == 1'b1, "R10 arm applied before step", irq, 1);

      // R10: disarm in the same cycle as a counted line at zero
      do_reset();
      write_reg(16'hC003, 8'h00);
      pulse_line(4, 1'b1);
      write_reg(16'hC002, 8'h00);
      line_and_write(5, 16'hC002, 8'h00);
      check(irq == 1'b0, "R10 disarm applied before step", irq, 0);

      // R10: latch write in the same cycle as a counted line
      do_reset();
      write_reg(16'hC003, 8'h00);
      line_and_write(6, 16'hC005, 8'h02);
      check(irq == 1'b0, "R10 new latch used at once", irq, 0);
      pulse_line(7, 1'b1);
      check(irq == 1'b1, "R10 new latch expires", irq, 1);

      // R6: offset write blocked keeps zero offset
      do_reset();
      scramble_en = 1'b0;
      write_reg(16'hC006, 8'h80);
      write_reg(16'hC005, 8'h00);
      write_reg(16'hC003, 8'h00);
      pulse_line(8, 1'b1);
      check(irq == 1'b1, "R6 blocked offset leaves latch zero", irq, 1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule